// File: doc/BRIEF.md
# Keypad Matrix Scanner with Keymap

The block scans a key matrix with five scan outputs and five return inputs. Both sides are active low. Scan output 0 is not used and always stays high. Outputs 1 to 4 are pulled low one at a time, in turn. While a scan line is low, a pressed key on it pulls its return line low. The block reads the returns at the end of each scan slot and finds the first connected key in the frame. It debounces that result over several whole frames. It then turns the key's matrix position into a 5-bit code through a fixed, sparse keymap.

Each accepted press and each accepted release produces a one-cycle event strobe. The strobe comes with the key code and a flag that gives the event type. If more than one key is seen in a single frame, a sticky flag is set. A separate active-low power-key input is synchronised, and its falling edge gives its own one-cycle strobe. Both strobes are merged into a single interrupt line.

Top module: `keypad_scan`

## Requirements
- R1: Exactly one of `scan_n[4:1]` is low at any time, and `scan_n[0]` is always high. Each line stays low for SETTLE cycles, in the order 1, 2, 3, 4, then back to 1. After reset, line 1 is the one driven low.
- R2: The key codes are fixed. Digits 0 to 9 give codes 0 to 9, `*` gives 10, `#` gives 11, send gives 12, end gives 13, soft-left 14, up 15, down 16 and soft-right 17. Return 0 holds send (scan 1) and end (scan 2). Return 1 holds soft-left, up, down and soft-right on scans 1 to 4. Returns 2, 3 and 4 hold 1/4/7/`*`, 2/5/8/0 and 3/6/9/`#` on scans 1 to 4.
- R3: Return 0 on scans 3 and 4 is not connected. A low level seen there never produces an event.
- R4: A key held for DEBOUNCE consecutive frames produces one event: `evt_stb` high for one cycle, `evt_press`=1, and `evt_code` set to the key's code.
- R5: When a pressed key has been released for DEBOUNCE consecutive frames, one event is produced with `evt_press`=0 and the same code as the press.
- R6: A key held for only one frame produces no event.
- R7: If two or more connected keys are down, the key reported is the one on the lowest scan line, and on that line the lowest return. `multi_seen` then goes high and stays high until reset. It stays low while only single keys are pressed.
- R8: A falling edge on `pwr_n` gives one `pwr_stb` pulse, two clock edges after the input changes. Releasing the power key gives no pulse.
- R9: `irq` is high exactly when `evt_stb` or `pwr_stb` is high, including a cycle where both are high.
- R10: During and right after reset, `evt_stb`, `pwr_stb`, `irq` and `multi_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_n | input | 5 | Return lines 0..4, active low |
| pwr_n | input | 1 | Power key, active low |
| scan_n | output | 5 | Scan lines 0..4, active low |
| evt_stb | output | 1 | One-cycle key event strobe |
| evt_code | output | 5 | Key code of the last event |
| evt_press | output | 1 | 1 = press, 0 = release |
| multi_seen | output | 1 | Sticky flag: more than one key seen in a frame |
| pwr_stb | output | 1 | One-cycle power-key press strobe |
| irq | output | 1 | Interrupt, OR of both strobes |

## Verification
A debounced key event and a power-key edge can land in the same clock cycle. The shared interrupt must then still be high, and neither strobe may be lost. The bench provokes this case on purpose. It locks onto the start of a frame by watching scan line 1 fall, and presses a key at that moment. It then drops `pwr_n` exactly two edges before the edge where the DEBOUNCE-th frame ends. In the cycle after that edge it expects `evt_stb`, `pwr_stb` and `irq` all high together. A monitor also compares `irq` with the OR of the two strobes in every cycle.

// File: rtl/keypad_scan.sv
`timescale 1ns/1ps
module keypad_scan #(
  parameter int SETTLE   = 8,
  parameter int DEBOUNCE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] ret_n,
  input  logic       pwr_n,
  output logic [4:0] scan_n,
  output logic       evt_stb,
  output logic [4:0] evt_code,
  output logic       evt_press,
  output logic       multi_seen,
  output logic       pwr_stb,
  output logic       irq
);
  localparam int TW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam int CW = $clog2(DEBOUNCE + 1);

  logic [TW-1:0] tick;
  logic [1:0]    line;
  logic          fr_found, last_found, acc_found;
  logic [4:0]    fr_code, last_code, acc_code;
  logic [CW-1:0] cnt;
  logic          pwr_s1, pwr_s2;

  function automatic logic [5:0] kmap(input logic [1:0] ln, input logic [2:0] rt);
    case (rt)
      3'd0:    kmap = (ln == 2'd0) ? 6'h2C : (ln == 2'd1) ? 6'h2D : 6'h00;
      3'd1:    kmap = {1'b1, 5'd14 + {3'b0, ln}};
      3'd2:    kmap = {1'b1, 5'd1 + 5'd3 * {3'b0, ln}};
      3'd3:    kmap = (ln == 2'd3) ? 6'h20 : {1'b1, 5'd2 + 5'd3 * {3'b0, ln}};
      default: kmap = (ln == 2'd3) ? 6'h2B : {1'b1, 5'd3 + 5'd3 * {3'b0, ln}};
    endcase
  endfunction

  wire slot_end  = (tick == TW'(SETTLE - 1));
  wire frame_end = slot_end && (line == 2'd3);
  assign scan_n  = ~(5'b00010 << line);

  wire [4:0] m = ~ret_n & {4'b1111, (line < 2'd2)};
  logic [4:0] hit_code;
  logic       hit;
  always_comb begin
    hit = 1'b0;
    hit_code = 5'd0;
    for (int r = 4; r >= 0; r--)
      if (m[r]) begin
        hit = 1'b1;
        hit_code = kmap(line, 3'(r))[4:0];
      end
  end

  wire       f_found = fr_found | hit;
  wire [4:0] f_code  = fr_found ? fr_code : hit_code;
  wire       same    = (f_found == last_found) && (!f_found || f_code == last_code);
  wire [CW-1:0] cnt_n = !same ? CW'(1) : (cnt == CW'(DEBOUNCE)) ? cnt : cnt + CW'(1);
  wire       change  = (f_found != acc_found) || (f_found && f_code != acc_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0; line <= '0;
      fr_found <= 1'b0; fr_code <= '0;
      last_found <= 1'b0; last_code <= '0; cnt <= '0;
      acc_found <= 1'b0; acc_code <= '0;
      evt_stb <= 1'b0; evt_code <= '0; evt_press <= 1'b0;
      multi_seen <= 1'b0;
      pwr_s1 <= 1'b1; pwr_s2 <= 1'b1; pwr_stb <= 1'b0;
    end else begin
      evt_stb <= 1'b0;
      pwr_s1  <= pwr_n;
      pwr_s2  <= pwr_s1;
      pwr_stb <= pwr_s2 & ~pwr_s1;
      tick    <= slot_end ? '0 : tick + TW'(1);
      if (slot_end) begin
        line <= line + 2'd1;
        if ((fr_found && hit) || $countones(m) > 1) multi_seen <= 1'b1;
        if (frame_end) fr_found <= 1'b0;
        else if (!fr_found && hit) begin
          fr_found <= 1'b1;
          fr_code  <= hit_code;
        end
      end
      if (frame_end) begin
        last_found <= f_found;
        last_code  <= f_code;
        cnt        <= cnt_n;
        if (cnt_n == CW'(DEBOUNCE) && change) begin
          evt_stb <= 1'b1;
          if (acc_found) begin
            evt_code  <= acc_code;
            evt_press <= 1'b0;
            acc_found <= 1'b0;
          end else begin
            evt_code  <= f_code;
            evt_press <= 1'b1;
            acc_found <= 1'b1;
            acc_code  <= f_code;
          end
        end
      end
    end
  end

  assign irq = evt_stb | pwr_stb;

  p_scan_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_n[0] && $countones(~scan_n) == 1);
  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |-> evt_code <= 5'd17);
  p_evt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |=> !evt_stb);
  p_multi_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    multi_seen |=> multi_seen);
  p_pwr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_stb |=> !pwr_stb);
endmodule

// File: tb/sim_keypad_scan.sv
`timescale 1ns/1ps
module sim_keypad_scan;
  localparam int S  = 8;
  localparam int N  = 4;
  localparam int FR = 4 * S;

  logic clk = 1'b0, rst_n = 1'b0, pwr_n = 1'b1;
  logic [4:0] scan_n, ret_n, evt_code;
  logic evt_stb, evt_press, multi_seen, pwr_stb, irq;
  logic [4:0][4:0] keys;  // keys[scan][return]

  int n_chk = 0, n_bad = 0, n_evt = 0, n_pwr = 0, irq_bad = 0;
  int last_code = -1, last_press = -1;

  always #5 clk = ~clk;

  keypad_scan #(.SETTLE(S), .DEBOUNCE(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ret_n(ret_n), .pwr_n(pwr_n), .scan_n(scan_n),
    .evt_stb(evt_stb), .evt_code(evt_code), .evt_press(evt_press),
    .multi_seen(multi_seen), .pwr_stb(pwr_stb), .irq(irq));

  always_comb begin
    ret_n = 5'b11111;
    for (int s = 0; s < 5; s++)
      for (int r = 0; r < 5; r++)
        if (keys[s][r] && !scan_n[s]) ret_n[r] = 1'b0;
  end

  always @(negedge clk) if (rst_n) begin
    if (evt_stb) begin n_evt++; last_code = evt_code; last_press = evt_press; end
    if (pwr_stb) n_pwr++;
    if (irq !== (evt_stb | pwr_stb)) irq_bad++;
  end

  function automatic int exp_code(int s, int r);
    int idx;
    if (r == 0) return (s == 1) ? 12 : (s == 2) ? 13 : -1;
    if (r == 1) return 13 + s;
    idx = (s - 1) * 3 + (r - 2);
    if (idx < 9) return idx + 1;
    return (idx == 9) ? 10 : (idx == 10) ? 0 : 11;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle_wait(); repeat ((N + 2) * FR) @(posedge clk); @(negedge clk); endtask

  task automatic hit_key(input int s, input int r);
    int e0, c;
    c  = exp_code(s, r);
    e0 = n_evt;
    keys[s][r] = 1'b1;
    settle_wait();
    if (c < 0) begin
      chk(n_evt == e0, "R3 nc press", n_evt - e0, 0);
    end else begin
      chk(n_evt == e0 + 1 && last_press == 1, "R4 press event", n_evt - e0, 1);
      chk(last_code == c, "R2 code", last_code, c);
    end
    e0 = n_evt;
    keys[s][r] = 1'b0;
    settle_wait();
    if (c < 0) chk(n_evt == e0, "R3 nc release", n_evt - e0, 0);
    else chk(n_evt == e0 + 1 && last_press == 0 && last_code == c, "R5 release", last_code, c);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0, p0, cnt;
    void'($urandom(32'd17));
    keys = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!evt_stb && !pwr_stb && !irq && !multi_seen, "R10 reset outputs", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scan_n == 5'b11101, "R1 reset scan", scan_n, 5'b11101);
    chk(!multi_seen && !evt_stb, "R10 after reset", multi_seen, 0);

    // R1: dwell and order
    while (scan_n[4]) @(negedge clk);
    while (scan_n[1]) @(negedge clk);
    cnt = 0;
    while (!scan_n[1]) begin cnt++; @(negedge clk); end
    chk(cnt == S && !scan_n[2] && scan_n[0], "R1 dwell/order", cnt, S);

    // directed: every NC position and corner keys
    hit_key(3, 0);
    hit_key(4, 0);
    hit_key(1, 0);
    hit_key(4, 4);
    hit_key(4, 3);
    for (int i = 0; i < 16; i++) hit_key(1 + $urandom % 4, $urandom % 5);
    chk(multi_seen == 0, "R7 no multi on singles", multi_seen, 0);

    // R6: one-frame press
    e0 = n_evt;
    keys[2][2] = 1'b1;
    repeat (FR) @(posedge clk);
    @(negedge clk) keys[2][2] = 1'b0;
    settle_wait();
    chk(n_evt == e0, "R6 bounce ignored", n_evt - e0, 0);

    // R7: two keys, lowest scan wins
    e0 = n_evt;
    keys[2][3] = 1'b1; keys[1][4] = 1'b1;
    settle_wait();
    chk(n_evt == e0 + 1 && last_code == 3 && last_press == 1, "R7 lowest key", last_code, 3);
    chk(multi_seen == 1, "R7 multi set", multi_seen, 1);
    keys = '0;
    settle_wait();
    chk(last_code == 3 && last_press == 0, "R5 multi release", last_code, 3);
    chk(multi_seen == 1, "R7 multi sticky", multi_seen, 1);

    // R8: power key
    p0 = n_pwr;
    pwr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(n_pwr == p0 + 1, "R8 power press", n_pwr - p0, 1);
    pwr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_pwr == p0 + 1, "R8 power release silent", n_pwr - p0, 1);

    // R9: key event and power edge in the same cycle
    while (scan_n[4]) @(negedge clk);
    while (scan_n[1]) @(negedge clk);
    keys[3][2] = 1'b1;
    repeat (N * FR - 2) @(posedge clk);
    @(negedge clk) pwr_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(evt_stb && pwr_stb && irq, "R9 coincident irq", {evt_stb, pwr_stb, irq}, 7);
    chk(evt_code == 7 && evt_press, "R2 coincident code", evt_code, 7);
    keys = '0; pwr_n = 1'b1;
    settle_wait();
    chk(irq_bad == 0, "R9 irq equals strobes", irq_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule